// File: doc/BRIEF.md
# Single-wire ROM command processor

This block sits between the bit-level engine of a single-wire slave and its device-function layer. After every bus reset it collects an 8-bit ROM command, least significant bit first, and then performs the addressing that command calls for against a 64-bit device identifier. The identifier is laid out as `dev_id[7:0]` family code, `dev_id[55:8]` serial number and `dev_id[63:56]` check byte. Computing the check byte is not part of this block. The block keeps two flags. The resume flag lets a slave that was addressed earlier be selected again with a single byte. The overdrive flag tells the bit engine to use fast timing.

The bit engine presents each completed time slot on a valid/ready stream (`slot_valid`, `slot_ready`, `slot_bit`). `slot_bit` is the line level it sampled, so on a slot this block drives it is the AND of the master's bit and the slave's bit. For the slot ahead, the block states at all times whether it wants to drive (`drv_en`) and which value (`drv_bit`). The engine pulls the line low only when `drv_en` is 1 and `drv_bit` is 0. Back-pressure works as follows:
- While the block owns the bus, `slot_ready` is 1 and every slot is taken in the cycle it is offered.
- Once control passes to the function layer, `slot_ready` falls to 0 and stays there until the next bus reset. Those slots then belong to the function layer.

A bus reset arrives as a one-cycle pulse on `brst_valid`, qualified by `brst_long` for a reset long enough to drop overdrive. If a reset and a slot arrive in the same cycle, the reset wins.

Top module: `romcmd_top`

## Requirements
- R1: After `rst_n` is released, and before any bus reset, `fn_owns`, `fn_start`, `rc_flag`, `od_mode` and `drv_en` are 0, `slot_ready` is 1, and slots offered are taken without effect.
- R2: After a bus reset, eight taken slots form the command byte, first slot in bit 0. A byte other than F0h, 33h, 55h, CCh, A5h, 3Ch or 69h puts the block in a wait state. In the wait state slots are taken, `drv_en` stays 0, no flag changes, and control is never handed off until the next bus reset.
- R3: Read (33h) clears the resume flag. It then drives 64 slots with `drv_en`=1, where slot k carries `dev_id[k]`, so the family code goes first, then the serial number, then the check byte. After that it hands off.
- R4: Match (55h) clears the resume flag and compares 64 received slots with `dev_id`, bit 0 first. If all agree, it sets the resume flag and hands off. The first disagreement sends it to the wait state.
- R5: Search (F0h) clears the resume flag and runs 64 triplets. It drives `dev_id[i]`, then drives its complement, then takes the master's bit. A master bit unequal to `dev_id[i]` sends it to the wait state. After 64 agreeing triplets it sets the resume flag and hands off.
- R6: Skip (CCh) clears the resume flag and hands off at once.
- R7: Resume (A5h) hands off at once and keeps the resume flag when the flag is 1. When the flag is 0 it goes to the wait state.
- R8: Overdrive-skip (3Ch) sets `od_mode`, clears the resume flag and hands off at once.
- R9: Overdrive-match (69h) sets `od_mode` in the cycle after the eighth command slot, before any address slot, and then behaves as Match. On a mismatch, `od_mode` returns to the value it had before the command.
- R10: A bus reset in any state restarts command reception. It ends any hand-off and releases the line in the next cycle. A long reset clears `od_mode`, a short one leaves it unchanged, and neither kind touches `rc_flag`.
- R11: A hand-off raises `fn_start` for exactly the cycle in which `fn_owns` first goes high. `fn_owns` holds until the next bus reset, and while it is high both `slot_ready` and `drv_en` are 0.
- R12: `rc_flag` rises only together with a hand-off that follows a successful search or match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | ID_W | Device identifier (family, serial, check byte) |
| brst_valid | input | 1 | One-cycle pulse: bus reset seen |
| brst_long | input | 1 | Qualifies `brst_valid`: reset long enough to leave overdrive |
| slot_valid | input | 1 | A time slot has completed |
| slot_ready | output | 1 | Block takes the offered slot |
| slot_bit | input | 1 | Line level sampled in the slot |
| drv_en | output | 1 | Block drives the next slot |
| drv_bit | output | 1 | Value driven when `drv_en` is 1 |
| od_mode | output | 1 | Overdrive flag for the bit engine |
| rc_flag | output | 1 | Resume flag |
| fn_start | output | 1 | One-cycle pulse at hand-off |
| fn_owns | output | 1 | Function layer owns the bus |

## Verification
The properties assume three things about the inputs:
- `brst_valid` is a single-cycle pulse.
- `slot_valid` is never raised while `fn_owns` is high.
- `slot_bit` is the wired-AND of the master's bit and the slave's drive.

The bench meets these by driving every input on the falling edge. It offers one slot at a time and drops `slot_valid` after one cycle. It computes each line level from the `drv_en`/`drv_bit` values that were visible before the slot. It only ever ends a hand-off through a bus reset pulse.

// File: rtl/romcmd_pkg.sv
package romcmd_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_SEARCH   = 8'hF0;
  localparam logic [OP_W-1:0] OP_READ     = 8'h33;
  localparam logic [OP_W-1:0] OP_MATCH    = 8'h55;
  localparam logic [OP_W-1:0] OP_SKIP     = 8'hCC;
  localparam logic [OP_W-1:0] OP_RESUME   = 8'hA5;
  localparam logic [OP_W-1:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [OP_W-1:0] OP_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SRCH_T,
    ST_SRCH_C,
    ST_SRCH_D,
    ST_FUNC
  } rstate_e;

endpackage

// File: rtl/romcmd_deser.sv
// Collects a command word, first bit into bit 0.
module romcmd_deser #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic         bit_in,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-2:0]  sh;
  logic [CW-1:0] cnt;

  // word includes the bit being taken now
  assign word = {bit_in, sh};
  assign done = take && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (take) begin
      sh <= word[W-1:1];
      if (cnt != LAST) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/romcmd_walk.sv
// Steps through the identifier one bit at a time.
module romcmd_walk #(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            step,
  input  logic [ID_W-1:0] id,
  output logic            id_bit,
  output logic            last
);
  localparam int IW = $clog2(ID_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(ID_W - 1);

  logic [IW-1:0] idx;

  assign id_bit = id[idx];
  assign last   = (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx <= '0;
    else if (clr)            idx <= '0;
    else if (step && last)   idx <= '0;
    else if (step)           idx <= idx + 1'b1;
  end
endmodule

// File: rtl/romcmd_flags.sv
// Resume and overdrive flags, with a saved overdrive value for failed matches.
module romcmd_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rc_set,
  input  logic rc_clr,
  input  logic od_set,
  input  logic od_clr,
  input  logic od_save,
  input  logic od_restore,
  output logic rc,
  output logic od
);
  logic od_keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc      <= 1'b0;
      od      <= 1'b0;
      od_keep <= 1'b0;
    end else begin
      if (rc_set)      rc <= 1'b1;
      else if (rc_clr) rc <= 1'b0;

      if (od_save) od_keep <= od;

      if (od_clr)          od <= 1'b0;
      else if (od_restore) od <= od_keep;
      else if (od_set)     od <= 1'b1;
    end
  end
endmodule

// File: rtl/romcmd_top.sv
module romcmd_top
  import romcmd_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] dev_id,
  input  logic            brst_valid,
  input  logic            brst_long,
  input  logic            slot_valid,
  output logic            slot_ready,
  input  logic            slot_bit,
  output logic            drv_en,
  output logic            drv_bit,
  output logic            od_mode,
  output logic            rc_flag,
  output logic            fn_start,
  output logic            fn_owns
);

  rstate_e st, st_n;

  logic            take;
  logic            cmd_done;
  logic [OP_W-1:0] cmd_word;
  logic            id_bit, id_last;
  logic            walk_clr, walk_step;
  logic            rc_set, rc_clr, od_set, od_clr, od_save, od_restore;

  assign slot_ready = (st != ST_FUNC);
  assign take       = slot_valid && slot_ready && !brst_valid;
  assign fn_owns    = (st == ST_FUNC);
  assign drv_en     = (st == ST_READ) || (st == ST_SRCH_T) || (st == ST_SRCH_C);
  assign drv_bit    = (st == ST_SRCH_C) ? ~id_bit : id_bit;

  romcmd_deser #(.W(OP_W)) u_deser (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (brst_valid),
    .take   (take && (st == ST_CMD)),
    .bit_in (slot_bit),
    .done   (cmd_done),
    .word   (cmd_word)
  );

  romcmd_walk #(.ID_W(ID_W)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (walk_clr),
    .step   (walk_step),
    .id     (dev_id),
    .id_bit (id_bit),
    .last   (id_last)
  );

  romcmd_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .rc_set     (rc_set),
    .rc_clr     (rc_clr),
    .od_set     (od_set),
    .od_clr     (od_clr),
    .od_save    (od_save),
    .od_restore (od_restore),
    .rc         (rc_flag),
    .od         (od_mode)
  );

  always_comb begin
    st_n       = st;
    walk_clr   = 1'b0;
    walk_step  = 1'b0;
    rc_set     = 1'b0;
    rc_clr     = 1'b0;
    od_set     = 1'b0;
    od_clr     = 1'b0;
    od_save    = 1'b0;
    od_restore = 1'b0;

    if (brst_valid) begin
      st_n     = ST_CMD;
      walk_clr = 1'b1;
      od_clr   = brst_long;
    end else if (take) begin
      unique case (st)
        ST_CMD: begin
          walk_clr = 1'b1;
          if (cmd_done) begin
            unique case (cmd_word)
              OP_READ:     begin rc_clr = 1'b1; st_n = ST_READ; end
              OP_SKIP:     begin rc_clr = 1'b1; st_n = ST_FUNC; end
              OP_OD_SKIP:  begin rc_clr = 1'b1; od_set = 1'b1; st_n = ST_FUNC; end
              OP_MATCH:    begin rc_clr = 1'b1; od_save = 1'b1; st_n = ST_MATCH; end
              OP_OD_MATCH: begin
                rc_clr  = 1'b1;
                od_save = 1'b1;
                od_set  = 1'b1;
                st_n    = ST_MATCH;
              end
              OP_SEARCH:   begin rc_clr = 1'b1; st_n = ST_SRCH_T; end
              OP_RESUME:   st_n = rc_flag ? ST_FUNC : ST_WAIT;
              default:     st_n = ST_WAIT;
            endcase
          end
        end
        ST_READ: begin
          walk_step = 1'b1;
          if (id_last) st_n = ST_FUNC;
        end
        ST_MATCH: begin
          if (slot_bit != id_bit) begin
            od_restore = 1'b1;
            st_n       = ST_WAIT;
          end else begin
            walk_step = 1'b1;
            if (id_last) begin
              rc_set = 1'b1;
              st_n   = ST_FUNC;
            end
          end
        end
        ST_SRCH_T: st_n = ST_SRCH_C;
        ST_SRCH_C: st_n = ST_SRCH_D;
        ST_SRCH_D: begin
          if (slot_bit != id_bit) begin
            st_n = ST_WAIT;
          end else begin
            walk_step = 1'b1;
            if (id_last) begin
              rc_set = 1'b1;
              st_n   = ST_FUNC;
            end else begin
              st_n = ST_SRCH_T;
            end
          end
        end
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_WAIT;
      fn_start <= 1'b0;
    end else begin
      st       <= st_n;
      fn_start <= (st_n == ST_FUNC) && (st != ST_FUNC);
    end
  end

endmodule

// File: rtl/romcmd_chk.sv
module romcmd_chk (
  input logic clk,
  input logic rst_n,
  input logic brst_valid,
  input logic brst_long,
  input logic slot_valid,
  input logic slot_ready,
  input logic drv_en,
  input logic od_mode,
  input logic rc_flag,
  input logic fn_start,
  input logic fn_owns
);

  p_rc_rise_on_select_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_flag) |-> fn_owns);

  p_owner_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fn_owns |-> (!slot_ready && !drv_en));

  p_start_with_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fn_start |-> fn_owns);

  p_reset_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brst_valid |=> (!fn_owns && !drv_en));

  p_long_reset_drops_od_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_valid && brst_long) |=> !od_mode);

  p_short_reset_keeps_od_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_valid && !brst_long) |=> $stable(od_mode));

  p_od_rise_after_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od_mode) |-> $past(slot_valid && slot_ready));

endmodule

bind romcmd_top romcmd_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .brst_valid (brst_valid),
  .brst_long  (brst_long),
  .slot_valid (slot_valid),
  .slot_ready (slot_ready),
  .drv_en     (drv_en),
  .od_mode    (od_mode),
  .rc_flag    (rc_flag),
  .fn_start   (fn_start),
  .fn_owns    (fn_owns)
);

// File: tb/romcmd_top_tb.sv
`timescale 1ns/1ps
module romcmd_top_tb;

  localparam logic [63:0] ID = 64'hC35A1E7B904D2628;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] dev_id = ID;
  logic        brst_valid = 1'b0;
  logic        brst_long = 1'b0;
  logic        slot_valid = 1'b0;
  logic        slot_bit = 1'b1;
  logic        slot_ready, drv_en, drv_bit, od_mode, rc_flag, fn_start, fn_owns;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  romcmd_top #(.ID_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
    .brst_valid(brst_valid), .brst_long(brst_long),
    .slot_valid(slot_valid), .slot_ready(slot_ready), .slot_bit(slot_bit),
    .drv_en(drv_en), .drv_bit(drv_bit), .od_mode(od_mode), .rc_flag(rc_flag),
    .fn_start(fn_start), .fn_owns(fn_owns)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One slot; returns what the block showed for this slot. Ends just after a falling edge.
  task automatic slot(input bit mbit, output bit en, output bit val);
    en  = drv_en;
    val = drv_bit;
    slot_bit   = mbit & (en ? val : 1'b1);
    slot_valid = 1'b1;
    @(negedge clk);
    slot_valid = 1'b0;
  endtask

  task automatic bus_reset(input bit lng);
    brst_valid = 1'b1;
    brst_long  = lng;
    @(negedge clk);
    brst_valid = 1'b0;
    brst_long  = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit e, v;
    for (int i = 0; i < 8; i++) slot(b[i], e, v);
  endtask

  task automatic send_id(input logic [63:0] a);
    bit e, v;
    for (int i = 0; i < 64; i++) slot(a[i], e, v);
  endtask

  task automatic t_reset_state();
    check(fn_owns == 0 && fn_start == 0, "R1 owner", int'(fn_owns), 0);
    check(rc_flag == 0 && od_mode == 0, "R1 flags", int'({rc_flag, od_mode}), 0);
    check(drv_en == 0 && slot_ready == 1, "R1 line", int'({drv_en, slot_ready}), 1);
    send_byte(8'hCC);
    check(fn_owns == 0, "R1 slots before bus reset ignored", int'(fn_owns), 0);
  endtask

  task automatic t_read();
    int errs = 0;
    bit e, v;
    bus_reset(1);
    send_byte(8'h33);
    for (int k = 0; k < 64; k++) begin
      slot(1'b1, e, v);
      if (!(e && v == ID[k])) errs++;
    end
    check(errs == 0, "R3 read bits", errs, 0);
    check(fn_owns && rc_flag == 0, "R3 hand-off rc clear", int'({fn_owns, rc_flag}), 2);
  endtask

  task automatic t_skip();
    bus_reset(1);
    send_byte(8'hCC);
    check(fn_owns == 1 && rc_flag == 0, "R6 skip", int'({fn_owns, rc_flag}), 2);
    check(slot_ready == 0 && drv_en == 0, "R11 owner quiet", int'({slot_ready, drv_en}), 0);
  endtask

  task automatic t_match_ok_then_resume();
    bus_reset(1);
    send_byte(8'h55);
    check(fn_owns == 0, "R4 no hand-off before address", int'(fn_owns), 0);
    send_id(ID);
    check(fn_owns && rc_flag, "R4 match ok", int'({fn_owns, rc_flag}), 3);
    bus_reset(0);
    check(rc_flag == 1 && fn_owns == 0, "R10 reset keeps rc", int'({rc_flag, fn_owns}), 2);
    send_byte(8'hA5);
    check(fn_owns && rc_flag, "R7 resume with rc", int'({fn_owns, rc_flag}), 3);
  endtask

  task automatic t_resume_denied();
    bus_reset(1);
    send_byte(8'hCC);               // clears rc
    bus_reset(1);
    send_byte(8'hA5);
    check(fn_owns == 0, "R7 resume without rc", int'(fn_owns), 0);
    send_byte(8'hCC);               // ignored in wait
    check(fn_owns == 0 && drv_en == 0 && slot_ready == 1, "R2 wait ignores slots",
          int'({fn_owns, drv_en, slot_ready}), 1);
  endtask

  task automatic t_match_bad();
    logic [63:0] bad = ID ^ (64'd1 << 40);
    bus_reset(1);
    send_byte(8'h55);
    send_id(bad);
    check(fn_owns == 0 && rc_flag == 0, "R4 mismatch waits", int'({fn_owns, rc_flag}), 0);
  endtask

  task automatic t_search(input int stop);
    int errs = 0;
    bit e, v, on;
    on = 1;
    bus_reset(1);
    send_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      slot(1'b1, e, v);
      if (on && !(e && v == ID[i])) errs++;
      if (!on && e) errs++;
      slot(1'b1, e, v);
      if (on && !(e && v == ~ID[i])) errs++;
      if (!on && e) errs++;
      slot((i == stop) ? ~ID[i] : ID[i], e, v);
      if (e) errs++;
      if (i == stop) on = 0;
    end
    check(errs == 0, "R5 search triplets", errs, 0);
    check(fn_owns == (stop >= 64) && rc_flag == (stop >= 64), "R5 search end",
          int'({fn_owns, rc_flag}), (stop >= 64) ? 3 : 0);
  endtask

  task automatic t_od_skip();
    bus_reset(1);
    send_byte(8'h3C);
    check(od_mode && fn_owns && !rc_flag, "R8 od skip", int'({od_mode, fn_owns, rc_flag}), 6);
    bus_reset(0);
    check(od_mode == 1, "R10 short reset keeps od", int'(od_mode), 1);
    bus_reset(1);
    check(od_mode == 0, "R10 long reset clears od", int'(od_mode), 0);
  endtask

  task automatic t_od_match(input bit good);
    logic [63:0] a = good ? ID : (ID ^ (64'd1 << 10));
    bus_reset(1);
    send_byte(8'h69);
    check(od_mode == 1 && fn_owns == 0, "R9 od before address", int'({od_mode, fn_owns}), 2);
    send_id(a);
    if (good)
      check(od_mode && rc_flag && fn_owns, "R9 od match ok", int'({od_mode, rc_flag, fn_owns}), 7);
    else
      check(!od_mode && !rc_flag && !fn_owns, "R9 od match fail restores od",
            int'({od_mode, rc_flag, fn_owns}), 0);
  endtask

  task automatic t_unknown_and_restart();
    bit e, v;
    bus_reset(1);
    send_byte(8'h00);
    check(fn_owns == 0 && drv_en == 0, "R2 unknown command", int'({fn_owns, drv_en}), 0);
    bus_reset(1);
    for (int i = 0; i < 4; i++) slot(1'b1, e, v);   // partial byte
    bus_reset(1);
    send_byte(8'hCC);
    check(fn_owns == 1, "R10 reset mid-byte restarts", int'(fn_owns), 1);
  endtask

  task automatic t_start_pulse();
    int pulses = 0;
    bus_reset(1);
    send_byte(8'h3C);
    // fn_start visible in the same cycle fn_owns first rises
    check(fn_start == 1 && fn_owns == 1, "R11 start pulse", int'({fn_start, fn_owns}), 3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (fn_start) pulses++;
    end
    check(pulses == 0 && fn_owns == 1, "R11 single pulse, owner held", pulses, 0);
    bus_reset(1);
    check(fn_owns == 0 && slot_ready == 1, "R10 reset ends hand-off", int'({fn_owns, slot_ready}), 1);
    check(rc_flag == 0, "R12 rc not set by overdrive skip", int'(rc_flag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read();
    t_skip();
    t_match_ok_then_resume();
    t_resume_denied();
    t_match_bad();
    t_search(64);
    t_search(5);
    t_od_skip();
    t_od_match(1'b0);
    t_od_match(1'b1);
    t_unknown_and_restart();
    t_start_pulse();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule